// File: doc/BRIEF.md
# Saturating Table Compander with Data-Driven Normaliser

This block maps a 22-bit two's-complement sample through a small host-loaded table, one sample per clock. A programmable arithmetic right shift brings an 8-bit window of the sample to the bottom. Those 8 bits address the table: the top six choose a 32-bit word and the bottom two choose a byte inside it. When the window cannot hold the sample, the access is sent to one of two saturation words instead of the table. The same happens when the incoming sample already carries an overflow flag.

The chosen word can be used in two ways. Its selected byte can be placed on the top and/or bottom byte of the result, which gives an 8-bit to 8-bit mapping. It can also act as a per-level scale and offset. Bits 26..22 of the word then set a rounding shift of the original sample, and bits 21..0 are added afterwards. This gives a piecewise scale-plus-offset compression curve. A run bit separates host loading from transform operation. The result leaves three clocks after the sample enters, with a valid flag.

Top module: `lut_compander`

## Requirements
- R1: `out_valid` follows `in_valid` exactly 3 rising edges later, and each result belongs to the sample taken 3 edges earlier. During and after reset, `out_valid` and `out_data` are 0.
- R2: The window shift is `cfg_pre_shift` places of arithmetic right shift. Values above 16 act as 16. Address bits 7..2 of the shifted value pick table word 0..63. Bits 1..0 pick the byte: byte k is word bits 8k+7..8k.
- R3: With `cfg_pos_addr`=0, the window is signed (-128..127). A shifted value above 127 reads the upper saturation word. A shifted value below -128 reads the lower saturation word.
- R4: With `cfg_pos_addr`=1, the window is unsigned (0..255). Any negative sample reads the lower saturation word. A non-negative shifted value above 255 reads the upper saturation word.
- R5: `wr_addr` 64 is the upper saturation word and 65 is the lower one. `in_pos_ovf` forces the upper word and `in_neg_ovf` forces the lower one. These flags take priority over a window overflow in either direction, and `in_pos_ovf` wins if both are set.
- R6: Whenever a saturation word is read, for any reason, byte 3 (bits 31..24) is the selected byte.
- R7: The normaliser shift is a 5-bit two's-complement value, where positive means right shift. Right shifts add half an LSB and then truncate. Shifts -1 and -2 shift left without rounding. Any value outside -2..14 makes the normaliser output 0.
- R8: With `cfg_dyn_norm`=1 and `cfg_run`=1, the shift comes from bits 26..22 of the selected word. Otherwise it comes from `cfg_norm_shift`.
- R9: With `cfg_add_offset`=1, bits 21..0 of the selected word are added to the normaliser output. The sum wraps modulo 2^22 and an overflow is not flagged.
- R10: `cfg_byte_hi` replaces `out_data[21:14]` with the selected byte. `cfg_byte_lo` replaces `out_data[7:0]` with the selected byte.
- R11: Table writes take effect only while `cfg_run`=0, and a write made while `cfg_run`=1 leaves the entry unchanged. While `cfg_run`=0, the selected word is treated as zero: the byte and offset are 0 and the static shift is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample valid |
| in_data | input | 22 | Two's-complement sample |
| in_pos_ovf | input | 1 | Sample overflowed positively upstream |
| in_neg_ovf | input | 1 | Sample overflowed negatively upstream |
| cfg_run | input | 1 | 1 = transform active, 0 = host may load table |
| cfg_pos_addr | input | 1 | 1 = unsigned window, 0 = signed window |
| cfg_pre_shift | input | 5 | Window right-shift amount |
| cfg_dyn_norm | input | 1 | Take normaliser shift from the table word |
| cfg_norm_shift | input | 5 | Static normaliser shift (two's complement) |
| cfg_add_offset | input | 1 | Add the table offset to the normaliser output |
| cfg_byte_hi | input | 1 | Selected byte drives result bits 21..14 |
| cfg_byte_lo | input | 1 | Selected byte drives result bits 7..0 |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 7 | Entry: 0..63 table, 64 upper, 65 lower saturation |
| wr_data | input | 32 | Entry data |
| out_valid | output | 1 | Result valid |
| out_data | output | 22 | Result |

## Verification
An upstream overflow flag and a window overflow can occur on the same sample, and each one points the access at a saturation word. The bench provokes this with directed samples that carry `in_pos_ovf` while lying far below the signed window, and samples that carry `in_neg_ovf` while lying above it. Every case uses distinct saturation-word contents, so the output byte shows which word was read and that byte 3 was taken. A bench model computes the window test from plain integer range comparisons rather than bit patterns, so the expected word does not depend on how the design detects the overflow.

// File: rtl/lut_compander.sv
module lut_compander #(
  parameter int DW       = 22,
  parameter int WORD_AW  = 6,
  parameter int PSW      = 5,
  parameter int PRE_MAX  = 16,
  parameter int NSW      = 5,
  parameter int NORM_MIN = -2,
  parameter int NORM_MAX = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_data,
  input  logic                 in_pos_ovf,
  input  logic                 in_neg_ovf,
  input  logic                 cfg_run,
  input  logic                 cfg_pos_addr,
  input  logic [PSW-1:0]       cfg_pre_shift,
  input  logic                 cfg_dyn_norm,
  input  logic [NSW-1:0]       cfg_norm_shift,
  input  logic                 cfg_add_offset,
  input  logic                 cfg_byte_hi,
  input  logic                 cfg_byte_lo,
  input  logic                 wr_en,
  input  logic [WORD_AW:0]     wr_addr,
  input  logic [31:0]          wr_data,
  output logic                 out_valid,
  output logic [DW-1:0]        out_data
);
  localparam int FW     = WORD_AW + 2;
  localparam int HW     = DW - FW;
  localparam int NWORDS = 1 << WORD_AW;
  localparam int NENT   = NWORDS + 2;
  localparam int IXW    = WORD_AW + 1;
  localparam int TW     = 32;
  localparam logic [IXW-1:0] UP_IX = IXW'(NWORDS);
  localparam logic [IXW-1:0] LO_IX = IXW'(NWORDS + 1);

  // window prescaler and over/under-select detection
  logic [PSW-1:0]       pre_amt;
  logic signed [DW-1:0] pre_val;
  logic [HW-1:0]        hi_bits;
  logic                 neg, sgn_bad, f_over, f_under, take_up, take_lo, sat_any;

  assign pre_amt = (cfg_pre_shift > PSW'(PRE_MAX)) ? PSW'(PRE_MAX) : cfg_pre_shift;
  assign pre_val = $signed(in_data) >>> pre_amt;
  assign hi_bits = pre_val[DW-1:FW];
  assign neg     = in_data[DW-1];
  assign sgn_bad = hi_bits != {HW{pre_val[FW-1]}};
  assign f_over  = !neg && (cfg_pos_addr ? (|hi_bits) : sgn_bad);
  assign f_under = neg && (cfg_pos_addr || sgn_bad);
  assign take_up = in_pos_ovf || (!in_neg_ovf && f_over);
  assign take_lo = !in_pos_ovf && (in_neg_ovf || (!f_over && f_under));
  assign sat_any = take_up || take_lo;

  logic            s1_v, s1_force;
  logic [DW-1:0]   s1_data;
  logic [IXW-1:0]  s1_ix;
  logic [1:0]      s1_bsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_force <= 1'b0; s1_data <= '0; s1_ix <= '0; s1_bsel <= '0;
    end else begin
      s1_v     <= in_valid;
      s1_data  <= in_data;
      s1_force <= sat_any;
      s1_ix    <= take_up ? UP_IX : (take_lo ? LO_IX : {1'b0, pre_val[FW-1:2]});
      s1_bsel  <= sat_any ? 2'd3 : pre_val[1:0];
    end
  end

  // table with two saturation words
  logic [TW-1:0] tbl [NENT];

  always_ff @(posedge clk) begin
    if (wr_en && !cfg_run && (wr_addr < IXW'(NENT)))
      tbl[wr_addr] <= wr_data;
  end

  logic            s2_v;
  logic [DW-1:0]   s2_data;
  logic [TW-1:0]   s2_word;
  logic [1:0]      s2_bsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_data <= '0; s2_word <= '0; s2_bsel <= '0;
    end else begin
      s2_v    <= s1_v;
      s2_data <= s1_data;
      s2_word <= tbl[s1_ix];
      s2_bsel <= s1_bsel;
    end
  end

  // normaliser, output adder, byte overrides
  logic [TW-1:0]        eff_word;
  logic [7:0]           sel_byte;
  logic [NSW-1:0]       nsh, lsh;
  logic [NSW-2:0]       rsh;
  logic                 nsh_ok;
  logic signed [DW:0]   ext, rnd_add, rres, norm;
  logic [DW-1:0]        sum, res;

  assign eff_word = cfg_run ? s2_word : '0;
  assign sel_byte = eff_word[{s2_bsel, 3'b000} +: 8];
  assign nsh      = (cfg_dyn_norm && cfg_run) ? eff_word[DW +: NSW] : cfg_norm_shift;
  assign nsh_ok   = ($signed(nsh) >= NORM_MIN) && ($signed(nsh) <= NORM_MAX);
  assign rsh      = nsh[NSW-2:0];
  assign lsh      = NSW'(~nsh + 1'b1);
  assign ext      = {s2_data[DW-1], s2_data};
  assign rnd_add  = ($signed(nsh) > 0) ? ((DW+1)'(1) <<< (rsh - 1'b1)) : '0;
  assign rres     = (ext + rnd_add) >>> rsh;

  always_comb begin
    if (!nsh_ok)           norm = '0;
    else if (nsh[NSW-1])   norm = ext <<< lsh;
    else                   norm = rres;
  end

  assign sum = norm[DW-1:0] + (cfg_add_offset ? eff_word[DW-1:0] : '0);

  always_comb begin
    res = sum;
    if (cfg_byte_hi) res[DW-1:DW-8] = sel_byte;
    if (cfg_byte_lo) res[7:0]       = sel_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0;
    end else begin
      out_valid <= s2_v;
      out_data  <= res;
    end
  end

  // checks
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R1
  AST_SIGNED_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_pos_addr && !in_pos_ovf && !in_neg_ovf && !neg && sgn_bad) |=> (s1_ix == UP_IX)); // R3
  AST_POS_NEG_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_pos_addr && neg && !in_pos_ovf) |=> (s1_ix == LO_IX)); // R4
  AST_FLAG_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_pos_ovf) |=> (s1_ix == UP_IX)); // R5
  AST_SAT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_force) |=> (s2_bsel == 2'd3)); // R6
  AST_NORM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && !nsh_ok && !cfg_add_offset && !cfg_byte_hi && !cfg_byte_lo) |=> (out_data == '0)); // R7
endmodule

// File: tb/lut_compander_tb.sv
`timescale 1ns/1ps
module lut_compander_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_pos_ovf = 0, in_neg_ovf = 0;
  logic [21:0] in_data = '0;
  logic b_run = 0, b_pos = 0, b_dyn = 0, b_off = 0, b_hi = 0, b_lo = 0;
  logic [4:0] b_pre = '0, b_nst = '0;
  logic wr_en = 0;
  logic [6:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic out_valid;
  logic [21:0] out_data;

  always #2 clk = ~clk;

  lut_compander dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_pos_ovf(in_pos_ovf), .in_neg_ovf(in_neg_ovf), .cfg_run(b_run),
    .cfg_pos_addr(b_pos), .cfg_pre_shift(b_pre), .cfg_dyn_norm(b_dyn),
    .cfg_norm_shift(b_nst), .cfg_add_offset(b_off), .cfg_byte_hi(b_hi),
    .cfg_byte_lo(b_lo), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_data(out_data));

  int n_chk = 0, n_bad = 0;
  logic [31:0] mt [66];
  logic [21:0] exp_q [4096];
  string tag_q [4096];
  int wp = 0, rp = 0;
  string cur_tag = "R1";
  bit done = 0;

  function automatic logic [21:0] model(input logic [21:0] d, input logic po, input logic no);
    int v, s, ps, idx, bs, sh, nv;
    logic ov, un, sat;
    logic [31:0] w;
    logic [7:0] b;
    logic [21:0] r;
    v  = int'($signed(d));
    ps = (b_pre > 16) ? 16 : int'(b_pre);
    s  = v >>> ps;
    if (b_pos) begin un = (v < 0); ov = (v >= 0) && (s > 255); end
    else begin ov = (s > 127); un = (s < -128); end
    sat = po | no | ov | un;
    if (po) idx = 64; else if (no) idx = 65;
    else if (ov) idx = 64; else if (un) idx = 65;
    else idx = (s & 255) >> 2;
    bs = sat ? 3 : (s & 3);
    w  = b_run ? mt[idx] : 32'd0;
    b  = w[bs*8 +: 8];
    sh = (b_dyn && b_run) ? int'(w[26:22]) : int'(b_nst);
    if (sh >= 16) sh = sh - 32;
    if (sh >= 1 && sh <= 14) nv = (v + (1 << (sh - 1))) >>> sh;
    else if (sh == 0) nv = v;
    else if (sh == -1 || sh == -2) nv = v << (-sh);
    else nv = 0;
    if (b_off) nv = nv + int'(w[21:0]);
    r = nv[21:0];
    if (b_hi) r[21:14] = b;
    if (b_lo) r[7:0] = b;
    return r;
  endfunction

  task automatic check(input string req, input logic [21:0] act, input logic [21:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rp == wp) begin
        n_chk++; n_bad++;
        $display("FAIL R1: unexpected out_valid, got %h expected none", out_data);
      end else begin
        check(tag_q[rp % 4096], out_data, exp_q[rp % 4096]);
        rp++;
      end
    end
  end

  task automatic send(input logic [21:0] d, input logic po, input logic no);
    in_valid = 1; in_data = d; in_pos_ovf = po; in_neg_ovf = no;
    exp_q[wp % 4096] = model(d, po, no);
    tag_q[wp % 4096] = cur_tag;
    wp++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 0; in_pos_ovf = 0; in_neg_ovf = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1; wr_addr = 7'(a); wr_data = d;
    if (!b_run) mt[a] = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [21:0] rnd22();
    logic [21:0] x;
    x = 22'($urandom);
    return 22'($signed(x) >>> ($urandom % 22));
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    check("R1 reset valid", {21'd0, out_valid}, 22'd0);
    check("R1 reset data", out_data, 22'd0);
    rst_n = 1;
    @(negedge clk);

    // load table and saturation words while stopped
    for (int i = 0; i < 64; i++) begin
      w = $urandom;
      w[26:22] = 5'(int'($urandom % 19) - 3);
      wr(i, w);
    end
    wr(64, 32'hA5_3C_0F_12);
    wr(65, 32'h5A_C3_F0_21);
    b_run = 1;

    // signed window, byte output on both ends
    cur_tag = "R2 R3 R5 R6 R10";
    b_hi = 1; b_lo = 1; b_nst = 5'b10000;
    for (int p = 0; p <= 20; p++) begin
      b_pre = 5'(p);
      for (int k = 0; k < 12; k++) send(rnd22(), 0, 0);
      idle(4);
    end
    b_pre = 5'd4;
    send(22'd2047, 0, 0); send(22'd2048, 0, 0);
    send(-22'sd2048, 0, 0); send(-22'sd2049, 0, 0);
    idle(4);

    // unsigned window
    cur_tag = "R4";
    b_pos = 1;
    send(22'd4095, 0, 0); send(22'd4096, 0, 0); send(-22'sd1, 0, 0); send(22'd0, 0, 0);
    for (int p = 0; p <= 16; p += 2) begin
      b_pre = 5'(p);
      for (int k = 0; k < 12; k++) send(rnd22(), 0, 0);
      idle(4);
    end

    // flag vs window overflow in the same sample
    cur_tag = "R5";
    b_pos = 0; b_pre = 5'd0;
    send(-22'sd5000, 1, 0); send(22'd5000, 0, 1); send(22'd3, 1, 1);
    send(22'd10, 1, 0); send(22'd10, 0, 1);
    idle(4);

    // static normaliser sweep
    cur_tag = "R7";
    b_hi = 0; b_lo = 0;
    for (int s = 0; s < 32; s++) begin
      b_nst = 5'(s);
      send(22'h1FFFFF, 0, 0); send(22'h200000, 0, 0); send(22'd3, 0, 0);
      send(-22'sd3, 0, 0);
      for (int k = 0; k < 6; k++) send(rnd22(), 0, 0);
      idle(4);
    end

    // data-driven scale and table offset
    cur_tag = "R8 R9";
    b_dyn = 1; b_off = 1;
    for (int p = 0; p <= 16; p += 4) begin
      b_pre = 5'(p);
      for (int k = 0; k < 30; k++) send(rnd22(), $urandom % 8 == 0, 0);
      idle(4);
    end
    b_pos = 1; b_hi = 1;
    for (int k = 0; k < 30; k++) send(rnd22(), 0, $urandom % 8 == 0);
    idle(4);

    // access control
    cur_tag = "R11";
    b_pos = 0; b_pre = 5'd0; b_dyn = 0; b_off = 0; b_hi = 1; b_lo = 1; b_nst = 5'b10000;
    wr(5, ~mt[5]);
    send(22'd20, 0, 0); send(22'd21, 0, 0);
    idle(4);
    b_run = 0; b_dyn = 1; b_off = 1; b_nst = 5'd2; b_lo = 0;
    for (int k = 0; k < 20; k++) send(rnd22(), 0, 0);
    idle(4);
    b_run = 1;
    send(22'd22, 0, 0);
    idle(5);

    cur_tag = "R1";
    check("R1 drained", 22'(wp - rp), 22'd0);
    finish_run();
  end
endmodule